// File: doc/BRIEF.md
# I2C Bus State and Arbitration Monitor

This block observes the two wires of an I2C bus, already synchronized to the local clock, together with the levels the local side is driving onto them. It passes both lines through a spike filter and then finds START, repeated START and STOP conditions on the filtered levels. From these it tracks whether the bus state is unknown, idle, owned by the local master, or busy with someone else's traffic.

Four sticky status flags report arbitration lost, bus collision, bus error and clock hold. The same flags serve a local master and a local slave. Arbitration is checked whenever the local side is transmitting and has released SDA. This covers a data bit lost to a data bit and also a data bit lost to another master's START or repeated START. Software or a sequencer clears a flag by writing a one to its bit of the clear port. The byte sequencers of the controller read the bus state and the condition pulses.

Top module: `i2c_bus_monitor`

## Requirements
- R1: A filtered line takes a new raw level only after that level has been sampled on FILT_LEN consecutive clock edges (default 3). A pulse shorter than that has no effect on any output.
- R2: START is filtered SDA falling while filtered SCL is high, and STOP is filtered SDA rising while SCL is high. A START seen in state idle or unknown pulses startDet for one cycle. A START seen in state owned or busy pulses rstartDet instead. Every STOP pulses stopDet.
- R3: After reset busState is 0 (unknown) and flags is 0. A STOP moves busState to 1 (idle).
- R4: When both filtered lines stay high for IDLE_TIMEOUT consecutive cycles, busState becomes idle.
- R5: A START seen in state idle or unknown moves busState to 2 (owned) if sdaDrive is 0 at that moment, and to 3 (busy) otherwise. A repeated START leaves the state unchanged.
- R6: In state owned, a drive mismatch sets flags[0] (arbitration lost) and moves busState to busy. A drive mismatch is localTx high, sdaDrive released for more than FILT_LEN cycles, filtered SCL high and filtered SDA low. This holds also when the mismatch coincides with another master's START.
- R7: In any state other than owned, the start of a drive mismatch sets flags[1] (bus collision), and flags[0] stays 0.
- R8: A START or STOP sets flags[2] (bus error) when the bit position is between 2 and 8. The bit position is reset by every START and STOP, and each SCL rise while the bus is owned or busy advances it through 1 to 9 and then back to 1.
- R9: flags[3] (clock hold) is set when the local side has pulled SCL low and then released it, and SCL stays low for more than FILT_LEN cycles after the release. Clock activity from another device alone does not set it.
- R10: The flags are sticky. A one on flagClr[i] clears flags[i] at the next edge, unless the same edge sets it again, in which case the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sdaIn | input | 1 | Synchronized SDA level seen on the bus |
| sclIn | input | 1 | Synchronized SCL level seen on the bus |
| sdaDrive | input | 1 | Level the local side drives on SDA (1 = released) |
| sclDrive | input | 1 | Level the local side drives on SCL (1 = released) |
| localTx | input | 1 | Local master or slave is transmitting the current bit |
| flagClr | input | 4 | Write-one-to-clear, one bit per flag |
| busState | output | 2 | 0 unknown, 1 idle, 2 owned, 3 busy |
| flags | output | 4 | [0] arbitration lost, [1] collision, [2] bus error, [3] clock hold |
| startDet | output | 1 | One-cycle pulse on a START from idle or unknown |
| rstartDet | output | 1 | One-cycle pulse on a repeated START |
| stopDet | output | 1 | One-cycle pulse on a STOP |

## Verification
A raw line change that is first sampled at edge t reaches the filtered level after edge t+FILT_LEN-1. Every result that depends on it (state, flags and condition pulses) then appears after edge t+FILT_LEN. A flag clear takes effect at the first edge that samples it. The bench runs a behavioural model that follows these latencies on every clock edge and compares all outputs at the falling edge. The directed checks wait at least one bus half-period after each stimulus before they sample, so they never land in the pipeline window.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

  typedef enum logic [1:0] {
    BUS_UNKNOWN = 2'd0,
    BUS_IDLE    = 2'd1,
    BUS_OWNED   = 2'd2,
    BUS_BUSY    = 2'd3
  } busState_e;

  localparam int FLAG_W    = 4;
  localparam int FLAG_ARB  = 0;
  localparam int FLAG_COLL = 1;
  localparam int FLAG_BERR = 2;
  localparam int FLAG_HOLD = 3;

  // strobes from datapath to control
  typedef struct packed {
    logic startCond;
    logic stopCond;
    logic driveMismatch;
    logic sclHeld;
    logic idleTimeout;
    logic midByte;
    logic localLow;
  } busEvents_t;

  // control feedback to datapath
  typedef struct packed {
    logic busActive;
  } ctrlToDp_t;

endpackage

// File: rtl/i2cmon_glitch_filter.sv
module i2cmon_glitch_filter #(
  parameter int   FILT_LEN    = 3,
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic level
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_LEN - 1);

  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level  <= RESET_LEVEL;
      runCnt <= '0;
    end else if (rawIn != level) begin
      if (runCnt == LAST) begin
        level  <= rawIn;
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end else begin
      runCnt <= '0;
    end
  end

  // R1: a change of the filtered level always takes the raw level last sampled
  p_filter_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    (level != $past(level)) |-> ($past(rawIn) == level));

endmodule

// File: rtl/i2cmon_datapath.sv
module i2cmon_datapath
  import i2cmon_pkg::*;
#(
  parameter int FILT_LEN     = 3,
  parameter int IDLE_TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaRaw,
  input  logic       sclRaw,
  input  logic       sdaDrive,
  input  logic       sclDrive,
  input  logic       localTx,
  input  ctrlToDp_t  ctrl,
  output busEvents_t ev
);
  localparam int GUARD   = FILT_LEN + 1;
  localparam int AGE_W   = $clog2(GUARD + 1);
  localparam int TMO_W   = $clog2(IDLE_TIMEOUT + 1);
  localparam int POS_W   = 4;
  localparam int XFER_LEN = 9;
  localparam int LINES   = 2;

  logic [LINES-1:0] rawVec, lvlVec, driveVec;
  assign rawVec   = {sclRaw, sdaRaw};
  assign driveVec = {sclDrive, sdaDrive};

  // per line: spike filter and a saturating count of cycles since release
  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [AGE_W-1:0] ageQ;

      i2cmon_glitch_filter #(.FILT_LEN(FILT_LEN), .RESET_LEVEL(1'b1)) u_filt (
        .clk   (clk),
        .rstN  (rstN),
        .rawIn (rawVec[g]),
        .level (lvlVec[g])
      );

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                       ageQ <= '0;
        else if (!driveVec[g])           ageQ <= '0;
        else if (ageQ != AGE_W'(GUARD))  ageQ <= ageQ + 1'b1;
      end
    end
  endgenerate

  logic sdaF, sclF, sdaPrev, sclPrev;
  logic [AGE_W-1:0] sdaAge, sclAge;
  assign sdaF   = lvlVec[0];
  assign sclF   = lvlVec[1];
  assign sdaAge = g_line[0].ageQ;
  assign sclAge = g_line[1].ageQ;

  logic [POS_W-1:0] bitPos;
  logic [TMO_W-1:0] highCnt;
  logic mismatchPrev, sclArmed;
  logic startC, stopC, sclRise, mismatch;

  always_comb begin
    startC   = sclF & sclPrev & sdaPrev & ~sdaF;
    stopC    = sclF & sclPrev & ~sdaPrev & sdaF;
    sclRise  = sclF & ~sclPrev;
    mismatch = localTx & sclF & sdaDrive & ~sdaF & (sdaAge >= AGE_W'(GUARD));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaPrev      <= 1'b1;
      sclPrev      <= 1'b1;
      bitPos       <= '0;
      highCnt      <= '0;
      mismatchPrev <= 1'b0;
      sclArmed     <= 1'b0;
    end else begin
      sdaPrev      <= sdaF;
      sclPrev      <= sclF;
      mismatchPrev <= mismatch;

      if (startC || stopC)
        bitPos <= '0;
      else if (sclRise && ctrl.busActive)
        bitPos <= (bitPos == POS_W'(XFER_LEN)) ? POS_W'(1) : bitPos + 1'b1;

      if (sclF && sdaF) begin
        if (highCnt != TMO_W'(IDLE_TIMEOUT)) highCnt <= highCnt + 1'b1;
      end else begin
        highCnt <= '0;
      end

      if (!sclDrive)  sclArmed <= 1'b1;
      else if (sclF)  sclArmed <= 1'b0;
    end
  end

  always_comb begin
    ev.startCond     = startC;
    ev.stopCond      = stopC;
    ev.driveMismatch = mismatch & ~mismatchPrev;
    ev.sclHeld       = sclArmed & sclDrive & ~sclF & (sclAge >= AGE_W'(GUARD));
    ev.idleTimeout   = (highCnt == TMO_W'(IDLE_TIMEOUT)) & sclF & sdaF;
    ev.midByte       = (bitPos >= POS_W'(2)) && (bitPos <= POS_W'(8));
    ev.localLow      = ~sdaDrive;
  end

  // R9: a hold is only reported after the local side has released SCL for two edges at least
  p_held_needs_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    ev.sclHeld |-> (sclDrive && $past(sclDrive)));

  // R6: a mismatch is only reported while the local side transmits a released bit
  p_mismatch_needs_tx_r6: assert property (@(posedge clk) disable iff (!rstN)
    ev.driveMismatch |-> (localTx && sdaDrive && $past(sdaDrive)));

endmodule

// File: rtl/i2cmon_control.sv
module i2cmon_control
  import i2cmon_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busEvents_t        ev,
  input  logic [FLAG_W-1:0] flagClr,
  output busState_e         stateQ,
  output logic [FLAG_W-1:0] flagsQ,
  output logic              startPulse,
  output logic              rstartPulse,
  output logic              stopPulse,
  output ctrlToDp_t         ctrl
);
  busState_e         stateNext;
  logic [FLAG_W-1:0] flagSet;
  logic              active;

  assign active         = (stateQ == BUS_OWNED) || (stateQ == BUS_BUSY);
  assign ctrl.busActive = active;

  always_comb begin
    stateNext = stateQ;
    if (ev.idleTimeout && stateQ != BUS_IDLE) stateNext = BUS_IDLE;
    if (ev.stopCond) stateNext = BUS_IDLE;
    if (ev.startCond && !active) stateNext = ev.localLow ? BUS_OWNED : BUS_BUSY;
    if (ev.driveMismatch && stateQ == BUS_OWNED) stateNext = BUS_BUSY;
  end

  always_comb begin
    flagSet            = '0;
    flagSet[FLAG_ARB]  = ev.driveMismatch && (stateQ == BUS_OWNED);
    flagSet[FLAG_COLL] = ev.driveMismatch && (stateQ != BUS_OWNED);
    flagSet[FLAG_BERR] = (ev.startCond || ev.stopCond) && ev.midByte;
    flagSet[FLAG_HOLD] = ev.sclHeld;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= BUS_UNKNOWN;
      flagsQ      <= '0;
      startPulse  <= 1'b0;
      rstartPulse <= 1'b0;
      stopPulse   <= 1'b0;
    end else begin
      stateQ      <= stateNext;
      flagsQ      <= (flagsQ & ~flagClr) | flagSet;
      startPulse  <= ev.startCond && !active;
      rstartPulse <= ev.startCond && active;
      stopPulse   <= ev.stopCond;
    end
  end

  // R3: a STOP always leaves the bus idle
  p_stop_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    ev.stopCond |=> (stateQ == BUS_IDLE));

  // R4: a timeout with both lines high always leaves the bus idle
  p_timeout_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    ev.idleTimeout |=> (stateQ == BUS_IDLE));

  // R5: ownership is only entered through a START driven locally
  p_owned_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == BUS_OWNED && $past(stateQ) != BUS_OWNED) |-> $past(ev.startCond && ev.localLow));

  // R6: losing arbitration flags it and gives up the bus
  p_arb_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ev.driveMismatch && stateQ == BUS_OWNED) |=> (stateQ == BUS_BUSY && flagsQ[FLAG_ARB]));

  // R8: a condition inside a byte raises the bus error flag
  p_berr_mid_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((ev.startCond || ev.stopCond) && ev.midByte) |=> flagsQ[FLAG_BERR]);

  // R2: the two START pulses never occur together
  p_start_kinds_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startPulse, rstartPulse}));

  // R10: a flag only drops through its clear bit
  generate
    for (genvar i = 0; i < FLAG_W; i++) begin : g_sticky
      p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
        (flagsQ[i] && !flagClr[i]) |=> flagsQ[i]);
    end
  endgenerate

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter int FILT_LEN     = 3,
  parameter int IDLE_TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaIn,
  input  logic       sclIn,
  input  logic       sdaDrive,
  input  logic       sclDrive,
  input  logic       localTx,
  input  logic [3:0] flagClr,
  output logic [1:0] busState,
  output logic [3:0] flags,
  output logic       startDet,
  output logic       rstartDet,
  output logic       stopDet
);
  busEvents_t ev;
  ctrlToDp_t  ctrl;
  busState_e  stateQ;

  i2cmon_datapath #(.FILT_LEN(FILT_LEN), .IDLE_TIMEOUT(IDLE_TIMEOUT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sdaRaw   (sdaIn),
    .sclRaw   (sclIn),
    .sdaDrive (sdaDrive),
    .sclDrive (sclDrive),
    .localTx  (localTx),
    .ctrl     (ctrl),
    .ev       (ev)
  );

  i2cmon_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .ev          (ev),
    .flagClr     (flagClr),
    .stateQ      (stateQ),
    .flagsQ      (flags),
    .startPulse  (startDet),
    .rstartPulse (rstartDet),
    .stopPulse   (stopDet),
    .ctrl        (ctrl)
  );

  assign busState = stateQ;

endmodule

// File: tb/i2c_bus_monitor_tb_top.sv
`timescale 1ns/1ps
module i2c_bus_monitor_tb_top;
  localparam int FILT = 3;
  localparam int TMO  = 64;
  localparam int G    = FILT + 1;
  localparam int H    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic sdaDrive = 1, sclDrive = 1, sdaOther = 1, sclOther = 1, localTx = 0;
  logic [3:0] flagClr = '0;
  logic sdaBus, sclBus;
  assign sdaBus = sdaDrive & sdaOther;
  assign sclBus = sclDrive & sclOther;

  logic [1:0] busState;
  logic [3:0] flags;
  logic startDet, rstartDet, stopDet;

  i2c_bus_monitor #(.FILT_LEN(FILT), .IDLE_TIMEOUT(TMO)) dut_i (
    .clk(clk), .rstN(rstN), .sdaIn(sdaBus), .sclIn(sclBus),
    .sdaDrive(sdaDrive), .sclDrive(sclDrive), .localTx(localTx),
    .flagClr(flagClr), .busState(busState), .flags(flags),
    .startDet(startDet), .rstartDet(rstartDet), .stopDet(stopDet)
  );

  int nChecks = 0, nFail = 0;
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mSda, mScl, runSda, runScl, pSda, pScl, pos, hiRun, ageD, ageC, mmLast, armed;
  int st, fl, pStart, pRst, pStop;

  always @(posedge clk) begin
    if (!rstN) begin
      mSda = 1; mScl = 1; runSda = 0; runScl = 0; pSda = 1; pScl = 1;
      pos = 0; hiRun = 0; ageD = 0; ageC = 0; mmLast = 0; armed = 0;
      st = 0; fl = 0; pStart = 0; pRst = 0; pStop = 0;
    end else begin
      int rs, rc, isStart, isStop, rise, mm, mmEdge, held, tmo, mid, act, nst, setv;
      rs = sdaBus; rc = sclBus;
      isStart = mScl && pScl && pSda && !mSda;
      isStop  = mScl && pScl && !pSda && mSda;
      rise    = mScl && !pScl;
      mm      = localTx && mScl && sdaDrive && !mSda && (ageD >= G);
      mmEdge  = mm && !mmLast;
      held    = armed && sclDrive && !mScl && (ageC >= G);
      tmo     = (hiRun == TMO) && mScl && mSda;
      mid     = (pos >= 2) && (pos <= 8);
      act     = (st == 2) || (st == 3);
      nst = st;
      if (tmo && st != 1) nst = 1;
      if (isStop) nst = 1;
      if (isStart && !act) nst = (sdaDrive == 0) ? 2 : 3;
      if (mmEdge && st == 2) nst = 3;
      setv = 0;
      if (mmEdge && st == 2) setv |= 1;
      if (mmEdge && st != 2) setv |= 2;
      if ((isStart || isStop) && mid) setv |= 4;
      if (held) setv |= 8;
      fl = (fl & ~int'(flagClr)) | setv;
      pStart = isStart && !act; pRst = isStart && act; pStop = isStop;
      if (isStart || isStop) pos = 0;
      else if (rise && act) pos = (pos == 9) ? 1 : pos + 1;
      hiRun = (mScl && mSda) ? ((hiRun < TMO) ? hiRun + 1 : TMO) : 0;
      ageD = sdaDrive ? ((ageD < G) ? ageD + 1 : G) : 0;
      ageC = sclDrive ? ((ageC < G) ? ageC + 1 : G) : 0;
      if (!sclDrive) armed = 1; else if (mScl) armed = 0;
      mmLast = mm;
      pSda = mSda; pScl = mScl;
      if (rs != mSda) begin if (runSda == FILT - 1) begin mSda = rs; runSda = 0; end else runSda++; end
      else runSda = 0;
      if (rc != mScl) begin if (runScl == FILT - 1) begin mScl = rc; runScl = 0; end else runScl++; end
      else runScl = 0;
      st = nst;
    end
  end

  // per-cycle comparison and pulse latches, away from the active edge
  int seenStart = 0, seenRst = 0, seenStop = 0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R5 model state", busState, st);
      check("R6 model arb flag", flags[0], fl & 1);
      check("R7 model collision flag", flags[1], (fl >> 1) & 1);
      check("R8 model bus error flag", flags[2], (fl >> 2) & 1);
      check("R9 model hold flag", flags[3], (fl >> 3) & 1);
      check("R2 model start pulse", startDet, pStart);
      check("R2 model rstart pulse", rstartDet, pRst);
      check("R2 model stop pulse", stopDet, pStop);
      if (startDet) seenStart = 1;
      if (rstartDet) seenRst = 1;
      if (stopDet) seenStop = 1;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearSeen();
    seenStart = 0; seenRst = 0; seenStop = 0;
  endtask

  task automatic clearFlags();
    flagClr = 4'hF; idle(1); flagClr = 4'h0; idle(1);
  endtask

  task automatic mBit(input logic d, input logic od, input logic tx);
    sdaDrive = d; sdaOther = od; localTx = tx; idle(H);
    sclDrive = 1; idle(H);
    sclDrive = 0; idle(H);
  endtask

  task automatic oBit(input logic od);
    sdaOther = od; idle(H);
    sclOther = 1; idle(H);
    sclOther = 0; idle(H);
  endtask

  task automatic localStart();
    sdaDrive = 0; idle(H);
    sclDrive = 0; idle(H);
  endtask

  task automatic otherStart();
    sdaOther = 0; idle(H);
    sclOther = 0; idle(H);
  endtask

  initial begin
    idle(3);
    rstN = 1;
    idle(1);
    // R3: reset values
    check("R3 reset state unknown", busState, 0);
    check("R3 reset flags clear", flags, 0);

    // R4: timeout with both lines high
    idle(TMO + FILT + 4);
    check("R4 timeout gives idle", busState, 1);

    // R5, R2: local START takes ownership
    clearSeen();
    localStart();
    check("R5 local start owns bus", busState, 2);
    check("R2 start pulse seen", seenStart, 1);
    for (int i = 7; i >= 0; i--) mBit(((8'hA5 >> i) & 1) != 0, 1'b1, 1'b1);
    mBit(1'b1, 1'b0, 1'b0);  // acknowledge from a slave
    check("R6 no arb on clean byte", flags[0], 0);
    check("R9 no hold on free clock", flags[3], 0);
    check("R8 no error on clean byte", flags[2], 0);

    // R2, R5: repeated START keeps ownership
    clearSeen();
    sdaOther = 1; sdaDrive = 1; idle(H);
    sclDrive = 1; idle(H);
    sdaDrive = 0; idle(H);
    sclDrive = 0; idle(H);
    check("R2 rstart pulse seen", seenRst, 1);
    check("R5 rstart keeps owned", busState, 2);
    check("R8 rstart after ack no error", flags[2], 0);

    // R3: local STOP
    clearSeen();
    sclDrive = 1; idle(H);
    sdaDrive = 1; idle(H);
    check("R3 stop gives idle", busState, 1);
    check("R2 stop pulse seen", seenStop, 1);

    // R1: spike one sample short of the filter length is ignored
    clearSeen();
    sdaOther = 0; idle(FILT - 1);
    sdaOther = 1; idle(H);
    check("R1 short spike no start", seenStart, 0);
    check("R1 short spike state idle", busState, 1);
    // R1: spike exactly the filter length passes
    sdaOther = 0; idle(FILT);
    sdaOther = 1; idle(H);
    check("R1 full pulse gives start", seenStart, 1);
    check("R1 full pulse gives stop", seenStop, 1);

    // R6: arbitration lost on a data bit
    localStart();
    sdaDrive = 1; localTx = 1; sdaOther = 0; idle(H);
    sclDrive = 1; idle(H);
    check("R6 arb flag on data bit", flags[0], 1);
    check("R6 arb gives busy", busState, 3);
    check("R7 no collision while owned", flags[1], 0);
    localTx = 0; sdaOther = 1; idle(H);
    check("R3 stop after arb idle", busState, 1);
    flagClr = 4'b0001; idle(1); flagClr = 4'b0000; idle(1);
    check("R10 clear arb flag", flags[0], 0);

    // R6: arbitration lost against another master's START
    clearSeen();
    localStart();
    sdaDrive = 1; localTx = 1; idle(H);
    sclDrive = 1; idle(H);
    sdaOther = 0; idle(H);
    check("R6 arb flag on foreign start", flags[0], 1);
    check("R6 foreign start gives busy", busState, 3);
    check("R2 foreign start is rstart", seenRst, 1);
    localTx = 0; sdaOther = 1; idle(H);
    clearFlags();

    // R7: collision while acting as slave transmitter
    clearSeen();
    otherStart();
    check("R5 foreign start busy", busState, 3);
    localTx = 1; sdaDrive = 1; idle(H);
    sclOther = 1; idle(H);
    check("R7 collision flag", flags[1], 1);
    check("R7 no arb when not owned", flags[0], 0);
    localTx = 0; sdaOther = 1; idle(H);
    check("R3 idle after slave stop", busState, 1);
    clearFlags();

    // R8: STOP in the third bit of a byte
    otherStart();
    oBit(1'b0); oBit(1'b0);
    sdaOther = 0; idle(H);
    sclOther = 1; idle(H);
    sdaOther = 1; idle(H);
    check("R8 bus error mid byte", flags[2], 1);
    check("R3 idle after early stop", busState, 1);
    clearFlags();

    // R9: clock hold after local release; foreign clock alone does not set it
    sclOther = 0; idle(H);
    check("R9 foreign low alone no hold", flags[3], 0);
    sclDrive = 0; idle(2);
    sclDrive = 1; idle(G + 4);
    check("R9 hold flag set", flags[3], 1);
    flagClr = 4'b1000; idle(1); flagClr = 4'b0000; idle(1);
    check("R10 set wins over clear", flags[3], 1);
    sclOther = 1; idle(H);
    flagClr = 4'b1000; idle(1); flagClr = 4'b0000; idle(1);
    check("R10 hold cleared", flags[3], 0);
    check("R9 state unaffected", busState, 1);

    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule